// File: doc/BRIEF.md
# Edge-Selectable Interrupt Capture Unit

This unit turns a 16-bit vector of internal event lines into one active-high interrupt request. Each event line is synchronized and compared with its previous sampled value. Firmware chooses, separately for each line, whether a low-to-high transition, a high-to-low transition, or both latch a sticky pending bit. The interrupt output is high whenever any pending bit is set.

A small synchronous register port gives access to two arming registers and one combined pending/clear register. A read at the pending/clear address returns the pending bits. A write there loads a clear mask that stays in force until it is overwritten. Firmware acknowledges by writing the mask of bits to drop and then writing zero. In a typical setup, line 11 signals that a conversion has finished. Line 12 is a pen-contact comparator, and only its falling transition is armed to detect a touch.

Top module: `edge_irq_capture`

## Requirements
- R1: After reset, both arming registers, the pending bits and `irq_o` are all zero.
- R2: A write to address 0x5E loads the rising-arm mask, and a write to 0x60 loads the falling-arm mask. Each reads back at the same address, with bit n belonging to event line n.
- R3: A low-to-high transition on line n sets pending bit n only when bit n of the rising-arm mask is 1. A transition on a line that is not armed leaves its pending bit at 0.
- R4: A high-to-low transition on line n sets pending bit n only when bit n of the falling-arm mask is 1. Writing zero to the falling-arm mask disarms every falling source.
- R5: A pending bit stays set after its event line returns to its former level, until it is cleared.
- R6: A read at 0x62 returns the pending bits, never the clear mask. Writing a mask there clears exactly the masked pending bits and leaves the others unchanged.
- R7: While clear-mask bit n is held at 1, pending bit n stays 0 even when an armed transition occurs. After the mask is rewritten to zero, new armed transitions set the bit again.
- R8: `irq_o` is a registered OR of the pending bits. It follows the pending bits one clock later.
- R9: Writing 0xFFFF and then 0x0000 to 0x62 leaves every pending bit at 0 and `irq_o` low.
- R10: Each event line passes through two synchronizer flops. A change seen at one clock edge sets the pending bit on the third rising edge after it, and not before.
- R11: Writes to any other address have no effect, and reads from any other address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Asynchronous event lines |
| reg_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is an armed transition that arrives while the clear mask is still held high. The bench has to keep the mask written, make the transition go all the way through the synchronizer, and then show that the pending bit stays low. Only after that does it write zero and fire a fresh transition to show the bit can be set again. The stimulus also mixes an armed and an unarmed line in the same cycle. It then clears one of two pending bits, to show that the clear acts on single bits.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  localparam int EVT_W_DEF  = 16;
  localparam int ADDR_W_DEF = 8;
  localparam logic [7:0] ADDR_RISE_ARM = 8'h5E;
  localparam logic [7:0] ADDR_FALL_ARM = 8'h60;
  localparam logic [7:0] ADDR_PEND_CLR = 8'h62;
  localparam int EVT_CONV_DONE = 11;
  localparam int EVT_PEN_PLUS_X = 12;
endpackage

// File: rtl/evt_edge_detect.sv
module evt_edge_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= evt_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic [W-1:0] rise_arm_i,
  input  logic [W-1:0] fall_arm_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] pend_q;

  for (genvar n = 0; n < W; n++) begin : g_bit
    logic hit;
    assign hit = (rise_i[n] & rise_arm_i[n]) | (fall_i[n] & fall_arm_i[n]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pend_q[n] <= 1'b0;
      else if (clr_mask_i[n])  pend_q[n] <= 1'b0;
      else if (hit)            pend_q[n] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |pend_q;
  end

  assign pend_o = pend_q;

  // R7
  clr_blocks_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask_i != '0) |=> ((pend_q & $past(clr_mask_i)) == '0));

  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |=> (($past(pend_q) & ~$past(clr_mask_i) & ~pend_q) == '0));
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_cap_pkg::*;
#(
  parameter int W      = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      pend_i,
  output logic [W-1:0]      rise_arm_o,
  output logic [W-1:0]      fall_arm_o,
  output logic [W-1:0]      clr_mask_o,
  output logic [W-1:0]      rdata_o
);
  localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(ADDR_RISE_ARM);
  localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(ADDR_FALL_ARM);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(ADDR_PEND_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_arm_o <= '0;
      fall_arm_o <= '0;
      clr_mask_o <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_RISE:  rise_arm_o <= wdata_i;
        A_FALL:  fall_arm_o <= wdata_i;
        A_PEND:  clr_mask_o <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_RISE:  rdata_o = rise_arm_o;
      A_FALL:  rdata_o = fall_arm_o;
      A_PEND:  rdata_o = pend_i;
      default: rdata_o = '0;
    endcase
  end

  // R2
  arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_RISE) |=> (rise_arm_o == $past(wdata_i)));
endmodule

// File: rtl/edge_irq_capture.sv
module edge_irq_capture
  import irq_cap_pkg::*;
#(
  parameter int EVT_W  = EVT_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [EVT_W-1:0]  reg_wdata_i,
  output logic [EVT_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [EVT_W-1:0] rise, fall, rise_arm, fall_arm, clr_mask, pend;

  evt_edge_detect #(.W(EVT_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rise_o(rise), .fall_o(fall)
  );

  irq_ctrl_regs #(.W(EVT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .pend_i(pend), .rise_arm_o(rise_arm),
    .fall_arm_o(fall_arm), .clr_mask_o(clr_mask), .rdata_o(reg_rdata_o)
  );

  irq_status_bank #(.W(EVT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
    .rise_arm_i(rise_arm), .fall_arm_i(fall_arm), .clr_mask_i(clr_mask),
    .pend_o(pend), .irq_o(irq_o)
  );

  // R8
  irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|pend)));
endmodule

// File: tb/sim_edge_irq_capture.sv
module sim_edge_irq_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int n_tests = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  edge_irq_capture u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd_reg(8'h5E, v); check("R1 rise arm", v, 16'h0);
    rd_reg(8'h60, v); check("R1 fall arm", v, 16'h0);
    rd_reg(8'h62, v); check("R1 pending", v, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr_reg(8'h5E, 16'h0800);
    wr_reg(8'h60, 16'h1000);
    rd_reg(8'h5E, v); check("R2 rise arm", v, 16'h0800);
    rd_reg(8'h60, v); check("R2 fall arm", v, 16'h1000);
    wr_reg(8'h40, 16'hFFFF);
    rd_reg(8'h40, v); check("R11 unmapped read", v, 16'h0);
    rd_reg(8'h5E, v); check("R11 rise unchanged", v, 16'h0800);
    rd_reg(8'h60, v); check("R11 fall unchanged", v, 16'h1000);
  endtask

  task automatic t_rise();
    logic [15:0] v;
    @(negedge clk);
    evt = 16'h0808;
    cyc(2);
    rd_reg(8'h62, v); check("R10 not yet after 2 edges", v, 16'h0);
    cyc(1);
    rd_reg(8'h62, v); check("R3 R10 armed rise only", v, 16'h0800);
    check("R8 irq lags pending", {15'd0, irq}, 16'h0);
    cyc(1);
    check("R8 irq high", {15'd0, irq}, 16'h1);
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    @(negedge clk);
    evt = 16'h0000;
    cyc(5);
    rd_reg(8'h62, v); check("R5 sticky", v, 16'h0800);
  endtask

  task automatic t_clear_hold();
    logic [15:0] v;
    wr_reg(8'h62, 16'h0800);
    cyc(2);
    rd_reg(8'h62, v); check("R6 read gives pending not mask", v, 16'h0);
    check("R8 irq low after clear", {15'd0, irq}, 16'h0);
    evt = 16'h0800;
    cyc(5);
    rd_reg(8'h62, v); check("R7 held clear blocks set", v, 16'h0);
    evt = 16'h0000;
    cyc(4);
    wr_reg(8'h62, 16'h0000);
    evt = 16'h1800;
    cyc(5);
    evt = 16'h0800;
    cyc(5);
    rd_reg(8'h62, v); check("R4 R7 fall and rise after release", v, 16'h1800);
    wr_reg(8'h62, 16'h0800);
    cyc(2);
    rd_reg(8'h62, v); check("R6 partial clear", v, 16'h1000);
    wr_reg(8'h62, 16'h0000);
  endtask

  task automatic t_clear_all();
    logic [15:0] v;
    wr_reg(8'h62, 16'hFFFF);
    wr_reg(8'h62, 16'h0000);
    cyc(2);
    rd_reg(8'h62, v); check("R9 all cleared", v, 16'h0);
    check("R9 irq low", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_disarm();
    logic [15:0] v;
    wr_reg(8'h60, 16'h0000);
    evt = 16'h1800;
    cyc(5);
    evt = 16'h0800;
    cyc(5);
    rd_reg(8'h62, v); check("R4 falling disarmed", v, 16'h0);
  endtask

  initial begin
    fork
      begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(2);
        t_regs();
        t_rise();
        t_sticky();
        t_clear_hold();
        t_clear_all();
        t_disarm();
      end
      begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule